// File: doc/BRIEF.md
# 1-2-4 Sample Clock Generator

The block produces sample-enable strobes from a 100 MHz master clock for a digitizing record path. In internal mode the time between strobes is a whole number of master-clock ticks (10 ns each). The number is set by a decade index and a mantissa of 1, 2 or 4. This gives intervals of 10, 20, 40, 100, 200, 400 ns and so on, one decade after another. In external mode each rising edge of an asynchronous sample clock is synchronized into the master domain and becomes one strobe. The internal divider then plays no part.

Two interval settings are held at the inputs, one for the part of a record before the trigger and one for the part after it. A select input chooses between them. The divider reads the chosen setting only at a strobe boundary, when it reloads, so a change of select or of a setting never cuts an interval short. A synchronized gate input suppresses strobes while low. The internal divider keeps running meanwhile, so strobes resume on the same grid. A registered toggle output shows that the master clock is running.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready interface and no back-pressure.

Top module: `smpclk_gen`

## Requirements
- R1: While rst_n is low and on the first sample after release, smp_en and mclk_ind are 0.
- R2: After reset, mclk_ind inverts on every master-clock cycle.
- R3: In internal mode with gate high, consecutive smp_en pulses are exactly M*10^D cycles apart. D is the decade index (0..7) and M is 1, 2 or 4 for mantissa codes 2'b00, 2'b01 and 2'b10.
- R4: Mantissa code 2'b11 is reserved and acts as a mantissa of 1.
- R5: For any interval of 2 or more cycles, and in external mode, smp_en is never high on two consecutive cycles.
- R6: use_post=0 selects the pre setting and use_post=1 selects the post setting. A change of use_post, or of the selected setting, during an interval leaves that interval at its old length; the new length applies from the next strobe onward.
- R7: In external mode, each rising edge of ext_clk gives exactly one smp_en pulse, whatever the interval settings.
- R8: While the synchronized gate_in is low, no smp_en pulse is issued, in either mode.
- R9: In internal mode, gating does not disturb the divider. The gap between the last strobe before a gated stretch and the first strobe after it is a whole multiple of the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_dec | input | 3 | Decade index of the pretrigger setting |
| pre_mant | input | 2 | Mantissa code of the pretrigger setting |
| post_dec | input | 3 | Decade index of the post-trigger setting |
| post_mant | input | 2 | Mantissa code of the post-trigger setting |
| use_post | input | 1 | 1 selects the post-trigger setting |
| ext_mode | input | 1 | 1 takes strobes from ext_clk instead of the divider |
| ext_clk | input | 1 | Asynchronous external sample clock |
| gate_in | input | 1 | Asynchronous strobe gate, active high |
| smp_en | output | 1 | One-cycle sample enable |
| mclk_ind | output | 1 | Master-clock running indication (toggles each cycle) |

## Verification
The hardest case is a select change that arrives partway through an interval. The stimulus has to land strictly between two boundaries, and the one gap that straddles the change must keep its old length. The bench first locks onto a strobe and counts cycles from it. It flips use_post (or rewrites the active setting) at a fixed count inside the interval, then compares each later gap with the old length followed by the new one, in both directions. Gate re-alignment is reached the same way: the bench drops the gate a few cycles after a strobe and raises it several intervals later, then checks that the straddling gap is a multiple of the interval.

// File: rtl/smpclk_pkg.sv
package smpclk_pkg;

  localparam int DEC_W_DEF = 3;

  typedef enum logic [1:0] {
    MANT_X1  = 2'b00,
    MANT_X2  = 2'b01,
    MANT_X4  = 2'b10,
    MANT_RSV = 2'b11
  } mant_e;

  function automatic longint pow10(input int k);
    longint r;
    r = 1;
    for (int i = 0; i < k; i++) r = r * 10;
    return r;
  endfunction

  // shift amount applied to the decade base for each mantissa code
  function automatic logic [1:0] mant_shift(input mant_e m);
    case (m)
      MANT_X2: return 2'd1;
      MANT_X4: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/smpclk_ratio.sv
module smpclk_ratio
  import smpclk_pkg::*;
#(
  parameter int DEC_W = 3,
  parameter int CNT_W = 26
) (
  input  logic [DEC_W-1:0] dec_i,
  input  logic [1:0]       mant_i,
  output logic [CNT_W-1:0] ratio_o
);
  localparam int N_DEC = 2 ** DEC_W;

  logic [CNT_W-1:0] base_tbl [N_DEC];

  generate
    for (genvar k = 0; k < N_DEC; k++) begin : g_base
      assign base_tbl[k] = CNT_W'(pow10(k));
    end
  endgenerate

  always_comb begin
    ratio_o = base_tbl[dec_i] << mant_shift(mant_e'(mant_i));
  end

endmodule

// File: rtl/smpclk_sync.sv
module smpclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk_i,
  input  logic gate_i,
  output logic ext_edge_o,
  output logic gate_o
);
  logic [STAGES-1:0] ext_sh;
  logic [STAGES-1:0] gate_sh;
  logic              ext_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_sh   <= '0;
      gate_sh  <= '0;
      ext_last <= 1'b0;
    end else begin
      ext_sh   <= {ext_sh[STAGES-2:0], ext_clk_i};
      gate_sh  <= {gate_sh[STAGES-2:0], gate_i};
      ext_last <= ext_sh[STAGES-1];
    end
  end

  assign ext_edge_o = ext_sh[STAGES-1] & ~ext_last;
  assign gate_o     = gate_sh[STAGES-1];

  AST_EXT_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge_o |=> !ext_edge_o); // R7

endmodule

// File: rtl/smpclk_divider.sv
module smpclk_divider #(
  parameter int CNT_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0) && !hold_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (hold_i) begin
      cnt_q <= '0;
    end else if (cnt_q == '0) begin
      cnt_q <= ratio_i - CNT_W'(1);
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  AST_RELOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> cnt_q == $past(ratio_i) - CNT_W'(1)); // R3
  AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R6

endmodule

// File: rtl/smpclk_gen.sv
module smpclk_gen
  import smpclk_pkg::*;
#(
  parameter int DEC_W       = DEC_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEC_W-1:0] pre_dec,
  input  logic [1:0]       pre_mant,
  input  logic [DEC_W-1:0] post_dec,
  input  logic [1:0]       post_mant,
  input  logic             use_post,
  input  logic             ext_mode,
  input  logic             ext_clk,
  input  logic             gate_in,
  output logic             smp_en,
  output logic             mclk_ind
);
  localparam longint MAX_RATIO = 4 * pow10(2 ** DEC_W - 1);
  localparam int     CNT_W     = $clog2(MAX_RATIO + 1);

  logic [DEC_W-1:0] sel_dec;
  logic [1:0]       sel_mant;
  logic [CNT_W-1:0] ratio;
  logic             int_tick;
  logic             ext_edge;
  logic             gate_s;
  logic             tick;

  assign sel_dec  = use_post ? post_dec  : pre_dec;
  assign sel_mant = use_post ? post_mant : pre_mant;

  smpclk_ratio #(.DEC_W(DEC_W), .CNT_W(CNT_W)) u_ratio (
    .dec_i   (sel_dec),
    .mant_i  (sel_mant),
    .ratio_o (ratio)
  );

  smpclk_divider #(.CNT_W(CNT_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (ext_mode),
    .ratio_i (ratio),
    .tick_o  (int_tick)
  );

  smpclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_clk_i  (ext_clk),
    .gate_i     (gate_in),
    .ext_edge_o (ext_edge),
    .gate_o     (gate_s)
  );

  assign tick = ext_mode ? ext_edge : int_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_en   <= 1'b0;
      mclk_ind <= 1'b0;
    end else begin
      smp_en   <= tick & gate_s;
      mclk_ind <= ~mclk_ind;
    end
  end

  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_s |=> !smp_en); // R8
  AST_MCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> mclk_ind != $past(mclk_ind)); // R2
  AST_EXT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && $past(ext_mode) && smp_en) |=> !smp_en); // R5

endmodule

// File: tb/smpclk_gen_tb.sv
module smpclk_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pre_dec = '0, post_dec = '0;
  logic [1:0] pre_mant = '0, post_mant = '0;
  logic       use_post = 1'b0, ext_mode = 1'b0, ext_clk = 1'b0, gate_in = 1'b1;
  logic       smp_en, mclk_ind;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  smpclk_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .pre_dec(pre_dec), .pre_mant(pre_mant),
    .post_dec(post_dec), .post_mant(post_mant),
    .use_post(use_post), .ext_mode(ext_mode), .ext_clk(ext_clk),
    .gate_in(gate_in), .smp_en(smp_en), .mclk_ind(mclk_ind)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_gap(output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!smp_en && g < 5000);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(smp_en == 0, "R1 smp_en in reset", smp_en, 0);
    check(mclk_ind == 0, "R1 mclk_ind in reset", mclk_ind, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(smp_en == 0, "R1 smp_en first cycle", smp_en, 0);
  endtask

  task automatic t_toggle;
    logic prev;
    prev = mclk_ind;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(mclk_ind != prev, "R2 toggle", mclk_ind, !prev);
      prev = mclk_ind;
    end
  endtask

  task automatic t_interval(input logic [2:0] d, input logic [1:0] m, input int exp, input string req);
    int g;
    use_post = 1'b0; pre_dec = d; pre_mant = m;
    next_gap(g); next_gap(g);
    for (int i = 0; i < 3; i++) begin
      next_gap(g);
      check(g == exp, req, g, exp);
      if (exp >= 2) begin
        @(negedge clk);
        check(smp_en == 0, "R5 single-cycle strobe", smp_en, 0);
        next_gap(g);
        check(g + 1 == exp, req, g + 1, exp);
      end
    end
  endtask

  task automatic t_switch;
    int g;
    int c;
    // pre 40 cycles, post 10 cycles; flip to post mid-interval (R6)
    pre_dec = 3'd1; pre_mant = 2'b10; post_dec = 3'd1; post_mant = 2'b00; use_post = 1'b0;
    next_gap(g); next_gap(g);
    c = 0;
    do begin
      @(negedge clk); c++;
      if (c == 15) use_post = 1'b1;
    end while (!smp_en && c < 5000);
    check(c == 40, "R6 straddling gap keeps old length", c, 40);
    next_gap(g);
    check(g == 10, "R6 new length after boundary", g, 10);
    // flip back to pre mid-interval
    c = 0;
    do begin
      @(negedge clk); c++;
      if (c == 4) use_post = 1'b0;
    end while (!smp_en && c < 5000);
    check(c == 10, "R6 shorter old interval finishes", c, 10);
    next_gap(g);
    check(g == 40, "R6 longer new length", g, 40);
    // rewrite the active setting mid-interval
    c = 0;
    do begin
      @(negedge clk); c++;
      if (c == 7) begin pre_dec = 3'd0; pre_mant = 2'b01; end
    end while (!smp_en && c < 5000);
    check(c == 40, "R6 setting change deferred", c, 40);
    next_gap(g);
    check(g == 2, "R6 new setting applied", g, 2);
  endtask

  task automatic t_ext(input bit gate, input int pulses, input int exp, input string req);
    int cnt;
    bit prev;
    bit dbl;
    cnt = 0; prev = 0; dbl = 0;
    pre_dec = 3'd0; pre_mant = 2'b00; use_post = 1'b0;
    gate_in = gate;
    ext_mode = 1'b1;
    repeat (8) @(negedge clk);
    for (int p = 0; p < pulses; p++) begin
      ext_clk = 1'b1;
      for (int i = 0; i < 2; i++) begin
        @(negedge clk);
        if (smp_en) cnt++;
        if (smp_en && prev) dbl = 1;
        prev = smp_en;
      end
      ext_clk = 1'b0;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        if (smp_en) cnt++;
        if (smp_en && prev) dbl = 1;
        prev = smp_en;
      end
    end
    repeat (8) begin
      @(negedge clk);
      if (smp_en) cnt++;
    end
    check(cnt == exp, req, cnt, exp);
    check(!dbl, "R5 ext strobe single cycle", dbl, 0);
    ext_mode = 1'b0;
    gate_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_gate_int;
    int cnt;
    cnt = 0;
    pre_dec = 3'd0; pre_mant = 2'b10; use_post = 1'b0;
    gate_in = 1'b0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (smp_en) cnt++;
    end
    check(cnt == 0, "R8 gated internal strobes", cnt, 0);
    gate_in = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_grid;
    int g;
    int c;
    pre_dec = 3'd1; pre_mant = 2'b00; use_post = 1'b0; gate_in = 1'b1;
    next_gap(g); next_gap(g);
    c = 0;
    do begin
      @(negedge clk); c++;
      if (c == 3) gate_in = 1'b0;
      if (c == 35) gate_in = 1'b1;
    end while (!smp_en && c < 5000);
    check(c % 10 == 0 && c > 10, "R9 grid kept across gate", c, 40);
    next_gap(g);
    check(g == 10, "R9 interval after gate", g, 10);
  endtask

  initial begin
    t_reset();
    t_toggle();
    t_interval(3'd0, 2'b00, 1,   "R3 1x10^0");
    t_interval(3'd0, 2'b01, 2,   "R3 2x10^0");
    t_interval(3'd0, 2'b10, 4,   "R3 4x10^0");
    t_interval(3'd1, 2'b00, 10,  "R3 1x10^1");
    t_interval(3'd1, 2'b01, 20,  "R3 2x10^1");
    t_interval(3'd1, 2'b10, 40,  "R3 4x10^1");
    t_interval(3'd2, 2'b00, 100, "R3 1x10^2");
    t_interval(3'd1, 2'b11, 10,  "R4 reserved mantissa");
    t_interval(3'd0, 2'b11, 1,   "R4 reserved mantissa d0");
    t_switch();
    t_ext(1'b1, 6, 6, "R7 one strobe per ext edge");
    t_ext(1'b0, 5, 0, "R8 gated ext strobes");
    t_gate_int();
    t_grid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule